// File: doc/BRIEF.md
# PWM Period and High-Time Meter

This block measures one external pulse-width-modulated signal. The pin is synchronised and passed through a digital glitch filter. The filtered level then feeds two capture channels. Channel 1 watches the level directly and captures on rising edges. Channel 2 receives the same level through a cross mapping and captures on falling edges. Both channels latch the value of a shared free-running 16-bit counter.

When the trigger selector picks channel 1's filtered, polarity-adjusted edge and slave reset is enabled, each channel-1 edge also clears the counter. With that set-up, capture register 1 holds the period and capture register 2 holds the high time, both as clock counts minus one. Software reads the capture registers, the sticky capture and overcapture flags, and the overflow flag. It clears each flag with a one-cycle write-1 pulse.

Top module: `pwm_meas`

## Requirements
- R1: The pin passes through two synchronising flip-flops and then a filter. The filter accepts a new level only after `filt_len_i` consecutive samples that differ from the current level; values 0 and 1 accept every change. With a length of 0 or 1, a capture becomes visible 4 clocks after the pin changes, and a length N above 1 adds N-1 clocks. A pulse shorter than N samples causes no capture.
- R2: Channel 1 captures only while `ch1_sel_i` is 2'b01. Its polarity bit selects the edge: 0 means rising, 1 means falling. At the capture edge, `cap1_o` takes the counter value of the edge cycle. Any other select value gives no capture.
- R3: Channel 2 captures only while `ch2_sel_i` is 2'b10, which cross-maps the filtered channel-1 level to it. With its polarity bit at 1 it captures on falling edges. Under slave reset, `cap2_o` therefore equals the high time in clocks minus one.
- R4: When `trig_sel_i` is 3'b101 and `slave_rst_en_i` is 1, each channel-1 edge clears the counter to 0 on the next clock. In that same clock, channel 1 captures the pre-clear value, so `cap1_o` equals the period in clocks minus one. Any other trigger select leaves the counter running.
- R5: The counter is 16 bits wide and adds one every clock when no trigger occurs.
- R6: On a count from 16'hFFFF the counter wraps to 0 and sets `ovf_o`. The flag stays set until `ovf_clr_i` is pulsed.
- R7: While a channel's bit in `cap_en_i` is 0, that channel's edges leave its capture register and capture flag unchanged.
- R8: A capture sets that channel's bit in `cap_flag_o`. The bit holds until that channel's bit of `cap_flag_clr_i` is pulsed. A capture in the same cycle as a clear leaves the flag set.
- R9: A capture while the channel's capture flag is set, and not being cleared, sets that channel's bit in `ovc_flag_o`. The bit holds until its `ovc_clr_i` bit is pulsed.
- R10: After reset, the counter, both capture registers and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Asynchronous PWM pin |
| filt_len_i | input | 4 | Filter sample count, 0 = off |
| ch1_sel_i | input | 2 | Channel 1 input select, 2'b01 = direct |
| ch2_sel_i | input | 2 | Channel 2 input select, 2'b10 = cross-mapped |
| ch1_pol_i | input | 1 | Channel 1 edge, 0 rising / 1 falling |
| ch2_pol_i | input | 1 | Channel 2 edge, 0 rising / 1 falling |
| trig_sel_i | input | 3 | Slave trigger source, 3'b101 = channel 1 filtered edge |
| slave_rst_en_i | input | 1 | Enables counter reset by the trigger |
| cap_en_i | input | 2 | Per-channel capture enable |
| cap_flag_clr_i | input | 2 | Per-channel capture flag clear pulse |
| ovc_clr_i | input | 2 | Per-channel overcapture flag clear pulse |
| ovf_clr_i | input | 1 | Overflow flag clear pulse |
| cap1_o | output | 16 | Channel 1 capture register |
| cap2_o | output | 16 | Channel 2 capture register |
| cap_flag_o | output | 2 | Per-channel capture flags |
| ovc_flag_o | output | 2 | Per-channel overcapture flags |
| ovf_o | output | 1 | Counter overflow flag |
| cnt_o | output | 16 | Current counter value |

## Verification
A pin change reaches a capture register and flag on the fourth rising clock after it is driven. That count is one synchroniser stage, a second synchroniser stage, the filter register, and then the capture. A filter length N above 1 moves the capture N-1 clocks later. The counter, the flag clears and the overflow flag all respond on the first clock after their cause. The bench drives inputs on falling edges and counts the rising edges in between. It samples at a falling edge that is at or after the due edge. The latency checks also look one edge early to confirm that nothing arrived before the due edge.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam logic [1:0] SEL_DIRECT = 2'b01;
  localparam logic [1:0] SEL_CROSS  = 2'b10;
  localparam logic [2:0] TRIG_CH1_FILT = 3'b101;

  function automatic logic [1:0] ch_sel_code(input int unsigned ch);
    return (ch == 0) ? SEL_DIRECT : SEL_CROSS;
  endfunction
endpackage

// File: rtl/pwm_in_filter.sv
module pwm_in_filter #(
  parameter int unsigned FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [FILT_W-1:0] len_i,
  output logic              lvl_o
);
  logic [1:0]        sync_q;
  logic [FILT_W-1:0] run_q;
  logic              lvl_q;
  logic              accept;

  assign accept = (len_i == '0) ||
                  (({1'b0, run_q} + 1'b1) >= {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      run_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (sync_q[1] == lvl_q) begin
        run_q <= '0;
      end else if (accept) begin
        lvl_q <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/pwm_cap_chan.sv
module pwm_cap_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             sel_ok_i,
  input  logic             pol_i,
  input  logic             en_i,
  input  logic             flag_clr_i,
  input  logic             ovc_clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             ovc_o
);
  logic             src, src_q;
  logic             cap_evt;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q, ovc_q;

  // unmapped select parks the input low
  assign src     = sel_ok_i & lvl_i;
  assign edge_o  = pol_i ? (src_q & ~src) : (src & ~src_q);
  assign cap_evt = edge_o & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= 1'b0;
      cap_q  <= '0;
      flag_q <= 1'b0;
      ovc_q  <= 1'b0;
    end else begin
      src_q <= src;
      if (cap_evt) cap_q <= cnt_i;
      if (cap_evt)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (cap_evt && flag_q && !flag_clr_i) ovc_q <= 1'b1;
      else if (ovc_clr_i)                   ovc_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign ovc_o  = ovc_q;
endmodule

// File: rtl/pwm_free_cnt.sv
module pwm_free_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= clr_i ? '0 : cnt_q + 1'b1;
      if (!clr_i && (cnt_q == '1)) ovf_q <= 1'b1;
      else if (ovf_clr_i)          ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/pwm_meas.sv
module pwm_meas
  import pwm_meas_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_i,
  input  logic [FILT_W-1:0] filt_len_i,
  input  logic [1:0]        ch1_sel_i,
  input  logic [1:0]        ch2_sel_i,
  input  logic              ch1_pol_i,
  input  logic              ch2_pol_i,
  input  logic [2:0]        trig_sel_i,
  input  logic              slave_rst_en_i,
  input  logic [1:0]        cap_en_i,
  input  logic [1:0]        cap_flag_clr_i,
  input  logic [1:0]        ovc_clr_i,
  input  logic              ovf_clr_i,
  output logic [CNT_W-1:0]  cap1_o,
  output logic [CNT_W-1:0]  cap2_o,
  output logic [1:0]        cap_flag_o,
  output logic [1:0]        ovc_flag_o,
  output logic              ovf_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic             lvl_w;
  logic             trig_w;
  logic [CNT_W-1:0] cnt_w;
  logic [1:0]       sel_w [NUM_CH];
  logic             pol_w [NUM_CH];
  logic             edge_w [NUM_CH];
  logic [CNT_W-1:0] cap_w [NUM_CH];
  logic             unused_edge;

  assign sel_w[0] = ch1_sel_i;
  assign sel_w[1] = ch2_sel_i;
  assign pol_w[0] = ch1_pol_i;
  assign pol_w[1] = ch2_pol_i;

  pwm_in_filter #(.FILT_W(FILT_W)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pwm_i),
    .len_i  (filt_len_i),
    .lvl_o  (lvl_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_cap_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (lvl_w),
      .sel_ok_i   (sel_w[g] == ch_sel_code(g)),
      .pol_i      (pol_w[g]),
      .en_i       (cap_en_i[g]),
      .flag_clr_i (cap_flag_clr_i[g]),
      .ovc_clr_i  (ovc_clr_i[g]),
      .cnt_i      (cnt_w),
      .edge_o     (edge_w[g]),
      .cap_o      (cap_w[g]),
      .flag_o     (cap_flag_o[g]),
      .ovc_o      (ovc_flag_o[g])
    );
  end

  // reset-mode slave: channel 1 edge clears the shared counter
  assign trig_w      = slave_rst_en_i && (trig_sel_i == TRIG_CH1_FILT) && edge_w[0];
  assign unused_edge = edge_w[1];

  pwm_free_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (trig_w),
    .ovf_clr_i (ovf_clr_i),
    .cnt_o     (cnt_w),
    .ovf_o     (ovf_o)
  );

  assign cnt_o  = cnt_w;
  assign cap1_o = cap_w[0];
  assign cap2_o = cap_w[1];
endmodule

// File: rtl/pwm_meas_chk.sv
module pwm_meas_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic [1:0]       cap_en_i,
  input logic [1:0]       cap_flag_clr_i,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cap1_o,
  input logic [CNT_W-1:0] cap2_o,
  input logic [1:0]       cap_flag_o,
  input logic             ovf_o
);
  a_r5_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  a_r4_trig_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> cnt_o == '0);

  a_r4_pre_clear_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && cap_en_i[0]) |=> (cap1_o == $past(cnt_o)) && cap_flag_o[0]);

  a_r6_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_o == '1) && !trig_i) |=> ovf_o);

  a_r6_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_clr_i && !((cnt_o == '1) && !trig_i)) |=> $stable(ovf_o));

  a_r7_cap2_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i[1] |=> $stable(cap2_o));

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_flag_o[0] && !cap_flag_clr_i[0]) |=> cap_flag_o[0]);
endmodule

bind pwm_meas pwm_meas_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .trig_i         (trig_w),
  .cap_en_i       (cap_en_i),
  .cap_flag_clr_i (cap_flag_clr_i),
  .ovf_clr_i      (ovf_clr_i),
  .cnt_o          (cnt_o),
  .cap1_o         (cap1_o),
  .cap2_o         (cap2_o),
  .cap_flag_o     (cap_flag_o),
  .ovf_o          (ovf_o)
);

// File: tb/pwm_meas_tb.sv
`timescale 1ns/1ps
module pwm_meas_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwm_i = 1'b0;
  logic [3:0]  filt_len_i = 4'd0;
  logic [1:0]  ch1_sel_i = 2'b01;
  logic [1:0]  ch2_sel_i = 2'b10;
  logic        ch1_pol_i = 1'b0;
  logic        ch2_pol_i = 1'b1;
  logic [2:0]  trig_sel_i = 3'b000;
  logic        slave_rst_en_i = 1'b1;
  logic [1:0]  cap_en_i = 2'b11;
  logic [1:0]  cap_flag_clr_i = 2'b00;
  logic [1:0]  ovc_clr_i = 2'b00;
  logic        ovf_clr_i = 1'b0;
  logic [15:0] cap1_o, cap2_o, cnt_o;
  logic [1:0]  cap_flag_o, ovc_flag_o;
  logic        ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam int NV = 5;
  localparam int V_PER [NV] = '{12, 20, 9, 40, 6};
  localparam int V_HI  [NV] = '{5, 7, 1, 33, 3};

  always #4 clk_i = ~clk_i;

  pwm_meas u_dut (.*);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic clear_flags();
    cap_flag_clr_i = 2'b11;
    ovc_clr_i = 2'b11;
    cyc(1);
    cap_flag_clr_i = 2'b00;
    ovc_clr_i = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    logic [15:0] c, v;
    cyc(3);
    rst_ni = 1'b1;
    // R10 reset state
    check("R10 cnt", cnt_o, 0);
    check("R10 cap1", cap1_o, 0);
    check("R10 cap2", cap2_o, 0);
    check("R10 flags", {cap_flag_o, ovc_flag_o, ovf_o}, 0);

    // R5 counting
    cyc(5);
    check("R5 count", cnt_o, 5);

    // R6 overflow wrap
    while (cnt_o != 16'hFFFF) cyc(1);
    check("R6 ovf before wrap", ovf_o, 0);
    cyc(1);
    check("R6 wrap", cnt_o, 0);
    check("R6 ovf set", ovf_o, 1);
    ovf_clr_i = 1'b1;
    cyc(1);
    ovf_clr_i = 1'b0;
    check("R6 ovf cleared", ovf_o, 0);

    // R4 other trigger select: counter keeps running, exact capture latency
    c = cnt_o;
    pwm_i = 1'b1;
    cyc(3);
    check("R1 no early capture", cap_flag_o[0], 0);
    cyc(5);
    check("R4 no reset", cnt_o, 32'(16'(c + 16'd8)));
    check("R2 rise capture", cap1_o, 32'(16'(c + 16'd3)));
    check("R8 flag0 set", cap_flag_o[0], 1);
    pwm_i = 1'b0;
    cyc(8);
    check("R3 fall capture", cap2_o, 32'(16'(c + 16'd11)));
    check("R9 no ovc", ovc_flag_o, 0);
    cap_flag_clr_i = 2'b11;
    cyc(1);
    cap_flag_clr_i = 2'b00;
    check("R8 flags cleared", cap_flag_o, 0);

    // vector table under slave reset
    trig_sel_i = 3'b101;
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 3; k++) begin
        pwm_i = 1'b1;
        cyc(V_HI[i]);
        pwm_i = 1'b0;
        cyc(V_PER[i] - V_HI[i]);
      end
      cyc(6);
      check("R4 period", cap1_o, V_PER[i] - 1);
      check("R3 high time", cap2_o, V_HI[i] - 1);
      check("R8 both flags", cap_flag_o, 2'b11);
      check("R9 overcapture", ovc_flag_o, 2'b11);
      clear_flags();
    end
    check("R9 ovc cleared", ovc_flag_o, 0);

    // R7 capture disable on channel 2
    cap_en_i = 2'b01;
    v = cap2_o;
    pwm_i = 1'b1;
    cyc(4);
    pwm_i = 1'b0;
    cyc(10);
    check("R7 cap2 held", cap2_o, 32'(v));
    check("R7 flag1 clear", cap_flag_o[1], 0);
    check("R7 ch1 still captures", cap_flag_o[0], 1);
    cap_en_i = 2'b11;
    clear_flags();

    // R2 unmapped channel 1 select
    ch1_sel_i = 2'b00;
    pwm_i = 1'b1;
    cyc(6);
    pwm_i = 1'b0;
    cyc(8);
    check("R2 sel off no capture", cap_flag_o[0], 0);
    ch1_sel_i = 2'b01;
    clear_flags();

    // R1 glitch filter N=3
    filt_len_i = 4'd3;
    cyc(2);
    pwm_i = 1'b1;
    cyc(2);
    pwm_i = 1'b0;
    cyc(8);
    check("R1 glitch rejected", cap_flag_o, 0);
    pwm_i = 1'b1;
    cyc(5);
    check("R1 filtered not yet", cap_flag_o[0], 0);
    cyc(1);
    check("R1 filtered latency", cap_flag_o[0], 1);
    pwm_i = 1'b0;
    cyc(10);

    finish_run();
  end
endmodule